// File: doc/BRIEF.md
# Double-Rate Sample Gearbox

The block narrows a sample stream as it crosses from a slow clock to a related fast clock. On every slow cycle it takes one wide word of four 32-bit samples. Each sample carries Q in bits 31:16 and I in bits 15:0. The block then presents that word as two consecutive words of two samples each, one per cycle of a fast clock running at exactly twice the rate. The two clocks have coincident rising edges.

The slow side always accepts: ready is high for as long as reset is released. The fast side has no backpressure. While no valid data is flowing, the output word is held at all zeros with valid low, so a converter downstream sees silence rather than stale samples.

Reset is active-low and belongs to the slow domain. The block carries it into the fast domain through a short register chain. A toggle launched from the slow domain marks each new slow cycle, and the fast side uses it to keep the half selection aligned.

Top module: `dual_rate_gearbox`

## Requirements
- R1: `in_ready` is 0 while `rst_slow_n` is low. It is 1 on every slow cycle from the first slow edge at which reset is sampled high, and it stays 1 until reset is asserted again.
- R2: After reset, and before any valid input arrives, `out_valid` is 0 and `out_data` is all zeros.
- R3: A word with `in_valid` high at a slow edge produces two output beats on consecutive fast cycles. The first beat is input bits 63:0 (samples 0 and 1, with sample 1 in bits 63:32). The second beat is input bits 127:64 (samples 2 and 3, with sample 3 in bits 63:32).
- R4: Every 32-bit sample reaches the output bit for bit, with Q in bits 31:16 and I in bits 15:0 of its lane. No lane is swapped or altered.
- R5: Latency is fixed. The first beat of a word captured at slow edge k is on the output after the fast edge that coincides with slow edge k+1, which is two fast cycles later. The second beat follows one fast cycle after that.
- R6: While `in_valid` stays high on consecutive slow edges, `out_valid` stays high on every fast cycle of the resulting output, with no bubbles. N words produce exactly 2N valid beats.
- R7: A slow edge with `in_valid` low produces two fast cycles with `out_valid` 0 and `out_data` zero, whatever is on `in_data`. Whenever `out_valid` is 0, `out_data` is 0.
- R8: The lower half of a word is always emitted first, whatever the pattern of valid and idle slow cycles before it.
- R9: When `rst_slow_n` is asserted in the middle of a stream, the fast-domain outputs are cleared within the reset-bridge depth plus one fast cycle. They then stay at zero until data is accepted again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_slow | input | 1 | Slow clock, input side |
| rst_slow_n | input | 1 | Active-low reset, synchronous to clk_slow |
| in_data | input | 128 | Four samples; sample n in bits 32n+31:32n |
| in_valid | input | 1 | Input word is valid on this slow edge |
| in_ready | output | 1 | High whenever reset is released |
| clk_fast | input | 1 | Fast clock, twice clk_slow, rising edges aligned |
| out_data | output | 64 | Two samples per fast cycle |
| out_valid | output | 1 | Output beat is valid |

## Verification
The hardest case to reach from the ports is a word whose first beat must fall on the fast cycle that begins halfway through a slow period, after an irregular run of idle slots. The half selector has to resynchronise to the slow cycle rather than to the history of valid data. The stimulus sends sparse patterns, such as one valid slot in two and one in three, and isolated single words after idle stretches of different lengths. A behavioural queue model is compared on every fast cycle, so a phase slip shows up as swapped halves. A reset asserted mid-burst covers the lag of the fast-side reset bridge.

// File: rtl/gbx_pkg.sv
package gbx_pkg;

    // Number of fast-domain register stages between capture and output.
    localparam int FAST_PIPE_STAGES = 2;

    // Classification of a fast cycle relative to the slow clock.
    typedef enum logic {
        SLOT_FIRST = 1'b0,
        SLOT_LATER = 1'b1
    } slot_e;

endpackage

// File: rtl/gbx_capture.sv
module gbx_capture #(
    parameter int WORD_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    output logic [WORD_W-1:0] cap_data,
    output logic              cap_valid,
    output logic              cap_tog,
    output logic              ready
);

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              valid;
        logic              tog;
        logic              ready;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.data  = '0;
            st_d.valid = 1'b0;
            st_d.tog   = 1'b0;
            st_d.ready = 1'b0;
        end else begin
            st_d.ready = 1'b1;
            st_d.tog   = ~st_q.tog;
            st_d.valid = in_valid;
            // Idle slots carry zeros so that the fast side never sees stale samples.
            st_d.data  = in_valid ? in_data : '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cap_data  = st_q.data;
    assign cap_valid = st_q.valid;
    assign cap_tog   = st_q.tog;
    assign ready     = st_q.ready;

endmodule

// File: rtl/gbx_rst_bridge.sv
module gbx_rst_bridge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_in_n,
    output logic rst_out_n
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d    = chain_q << 1;
        chain_d[0] = rst_in_n;
    end

    always_ff @(posedge clk) begin
        chain_q <= chain_d;
    end

    assign rst_out_n = chain_q[STAGES-1];

endmodule

// File: rtl/gbx_lane_select.sv
module gbx_lane_select
    import gbx_pkg::*;
#(
    parameter int HALF_W = 64,
    parameter int RATIO  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [HALF_W*RATIO-1:0] cap_data,
    input  logic                    cap_valid,
    input  logic                    cap_tog,
    output logic [HALF_W-1:0]       out_data,
    output logic                    out_valid
);

    localparam int PH_W = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(RATIO - 1);

    typedef struct packed {
        logic              tog_seen;
        logic [PH_W-1:0]   phase;
        logic [HALF_W-1:0] sel_data;
        logic              sel_valid;
        logic [HALF_W-1:0] out_data;
        logic              out_valid;
    } sel_st_t;

    sel_st_t           st_d, st_q;
    slot_e             slot_kind;
    logic [PH_W-1:0]   cur_phase;
    logic [HALF_W-1:0] picked;

    always_comb begin
        // A toggle that differs from the last one seen marks the first fast
        // cycle after a slow edge: that cycle takes the lowest slice.
        slot_kind = (cap_tog != st_q.tog_seen) ? SLOT_FIRST : SLOT_LATER;
        if (slot_kind == SLOT_FIRST) begin
            cur_phase = '0;
        end else if (st_q.phase != PH_LAST) begin
            cur_phase = st_q.phase + PH_W'(1);
        end else begin
            cur_phase = st_q.phase;
        end

        picked = '0;
        for (int r = 0; r < RATIO; r++) begin
            if (cur_phase == PH_W'(r)) begin
                picked = cap_data[r*HALF_W +: HALF_W];
            end
        end

        st_d           = st_q;
        st_d.tog_seen  = cap_tog;
        st_d.phase     = cur_phase;
        st_d.sel_valid = cap_valid;
        st_d.sel_data  = cap_valid ? picked : '0;
        st_d.out_valid = st_q.sel_valid;
        st_d.out_data  = st_q.sel_data;

        if (!rst_n) begin
            st_d.phase     = '0;
            st_d.sel_valid = 1'b0;
            st_d.sel_data  = '0;
            st_d.out_valid = 1'b0;
            st_d.out_data  = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign out_data  = st_q.out_data;
    assign out_valid = st_q.out_valid;

endmodule

// File: rtl/dual_rate_gearbox.sv
module dual_rate_gearbox #(
    parameter int SAMPLE_W   = 32,
    parameter int LANES_IN   = 4,
    parameter int LANES_OUT  = 2,
    parameter int RST_STAGES = 2
) (
    input  logic                            clk_slow,
    input  logic                            rst_slow_n,
    input  logic [SAMPLE_W*LANES_IN-1:0]    in_data,
    input  logic                            in_valid,
    output logic                            in_ready,
    input  logic                            clk_fast,
    output logic [SAMPLE_W*LANES_OUT-1:0]   out_data,
    output logic                            out_valid
);

    localparam int WORD_W = SAMPLE_W * LANES_IN;
    localparam int HALF_W = SAMPLE_W * LANES_OUT;
    localparam int RATIO  = LANES_IN / LANES_OUT;

    logic [WORD_W-1:0] cap_data;
    logic              cap_valid;
    logic              cap_tog;
    logic              rst_fast_n;

    gbx_capture #(
        .WORD_W (WORD_W)
    ) u_capture (
        .clk       (clk_slow),
        .rst_n     (rst_slow_n),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .cap_data  (cap_data),
        .cap_valid (cap_valid),
        .cap_tog   (cap_tog),
        .ready     (in_ready)
    );

    gbx_rst_bridge #(
        .STAGES (RST_STAGES)
    ) u_rst_bridge (
        .clk       (clk_fast),
        .rst_in_n  (rst_slow_n),
        .rst_out_n (rst_fast_n)
    );

    gbx_lane_select #(
        .HALF_W (HALF_W),
        .RATIO  (RATIO)
    ) u_lane_select (
        .clk       (clk_fast),
        .rst_n     (rst_fast_n),
        .cap_data  (cap_data),
        .cap_valid (cap_valid),
        .cap_tog   (cap_tog),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

endmodule

// File: rtl/gbx_checker.sv
module gbx_checker #(
    parameter int OUT_W = 64
) (
    input logic             clk_slow,
    input logic             clk_fast,
    input logic             rst_slow_n,
    input logic             rst_fast_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data
);

    AST_READY_HELD: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
        $past(rst_slow_n) |-> in_ready); // R1

    AST_IDLE_ZERO: assert property (@(posedge clk_fast) disable iff (!rst_fast_n)
        !out_valid |-> (out_data == '0)); // R7

    AST_PAIR_START: assert property (@(posedge clk_fast) disable iff (!rst_fast_n)
        $rose(out_valid) |=> out_valid); // R3

    AST_PAIR_END: assert property (@(posedge clk_fast) disable iff (!rst_fast_n)
        $fell(out_valid) |=> !out_valid); // R3

    AST_RESET_CLEAR: assert property (@(posedge clk_fast)
        !rst_fast_n |=> (!out_valid && out_data == '0)); // R9

endmodule

bind dual_rate_gearbox gbx_checker #(
    .OUT_W (SAMPLE_W * LANES_OUT)
) u_chk (
    .clk_slow   (clk_slow),
    .clk_fast   (clk_fast),
    .rst_slow_n (rst_slow_n),
    .rst_fast_n (rst_fast_n),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_data   (out_data)
);

// File: tb/sim_dual_rate_gearbox.sv
module sim_dual_rate_gearbox;

    localparam int SW = 32;
    localparam int LI = 4;
    localparam int LO = 2;
    localparam int WW = SW * LI;
    localparam int OW = SW * LO;

    logic          clk_slow   = 1'b0;
    logic          clk_fast   = 1'b0;
    logic          rst_slow_n = 1'b0;
    logic [WW-1:0] in_data    = '0;
    logic          in_valid   = 1'b0;
    logic          in_ready;
    logic [OW-1:0] out_data;
    logic          out_valid;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    dual_rate_gearbox u0 (
        .clk_slow   (clk_slow),
        .rst_slow_n (rst_slow_n),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .clk_fast   (clk_fast),
        .out_data   (out_data),
        .out_valid  (out_valid)
    );

    // Slow clock 50 MHz (20 ns), fast clock 100 MHz, rising edges aligned.
    initial begin
        forever begin
            #5 clk_fast = 1'b1;
            clk_slow = ~clk_slow;
            #5 clk_fast = 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [OW:0] act, input logic [OW:0] expv);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    function automatic logic [WW-1:0] make_word(input int base);
        logic [WW-1:0] w;
        for (int s = 0; s < LI; s++) begin
            w[s*SW +: SW] = {16'(base * 7 + s + 16'h4000), 16'(base * 3 + s + 16'h0100)};
        end
        return w;
    endfunction

    // Behavioural reference: queue of expected beats, two pushed per slow edge.
    typedef struct packed {
        logic          v;
        logic [OW-1:0] d;
    } beat_t;

    beat_t q[$];
    beat_t exp_b = '0;
    int    fast_edge = 0;
    int    settle = 0;

    initial begin
        q.push_back('0);
        q.push_back('0);
    end

    always @(posedge clk_fast) begin
        exp_b = (q.size() > 0) ? q.pop_front() : '0;
        if (fast_edge % 2 == 0) begin
            if (rst_slow_n && in_valid) begin
                q.push_back({1'b1, in_data[OW-1:0]});
                q.push_back({1'b1, in_data[WW-1:OW]});
            end else begin
                q.push_back('0);
                q.push_back('0);
            end
        end
        fast_edge++;
        if (!rst_slow_n) settle = 0;
        else if (settle < 8) settle++;
    end

    // Cycle-by-cycle comparison against the model (R3, R5, R7, R8).
    always @(negedge clk_fast) begin
        if (settle >= 8 && !done) begin
            chk("R3 R5 R7 R8 model", {out_valid, out_data}, exp_b);
        end
    end

    // Ready monitor (R1).
    bit ready_mon = 1'b0;
    always @(negedge clk_slow) begin
        if (ready_mon && !done) chk("R1 ready held", {{OW{1'b0}}, in_ready}, {{OW{1'b0}}, 1'b1});
    end

    // Bubble monitor (R6).
    bit mon_on = 1'b0;
    bit started = 1'b0;
    int beats = 0;
    int bubbles = 0;
    int low_run = 0;
    always @(negedge clk_fast) begin
        if (mon_on) begin
            if (out_valid) begin
                if (started) bubbles += low_run;
                started = 1'b1;
                low_run = 0;
                beats++;
            end else if (started) begin
                low_run++;
            end
        end
    end

    task automatic send(input bit v, input int base);
        @(posedge clk_slow);
        #2;
        in_valid = v;
        in_data  = v ? make_word(base) : make_word(base ^ 32'h5A5A);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    initial begin
        logic [WW-1:0] w;
        // Reset state (R1, R2).
        repeat (6) @(posedge clk_slow);
        @(negedge clk_fast);
        chk("R2 reset valid/data", {out_valid, out_data}, '0);
        chk("R1 ready in reset", {{OW{1'b0}}, in_ready}, '0);
        @(posedge clk_slow);
        #2 rst_slow_n = 1'b1;
        @(posedge clk_slow);
        #2 ready_mon = 1'b1;

        // Idle with junk data (R2, R7).
        for (int i = 0; i < 10; i++) send(1'b0, i);
        @(negedge clk_fast);
        chk("R2 idle after reset", {out_valid, out_data}, '0);

        // Isolated word: exact timing and lane content (R4, R5).
        w = make_word(77);
        send(1'b1, 77);
        send(1'b0, 3);
        @(posedge clk_slow);
        @(negedge clk_fast);
        chk("R5 first beat timing", {out_valid, out_data}, {1'b1, w[OW-1:0]});
        chk("R4 sample0 I", {{(OW-15){1'b0}}, out_data[15:0]}, {{(OW-15){1'b0}}, w[15:0]});
        chk("R4 sample1 Q", {{(OW-15){1'b0}}, out_data[63:48]}, {{(OW-15){1'b0}}, w[63:48]});
        @(negedge clk_fast);
        chk("R5 second beat", {out_valid, out_data}, {1'b1, w[WW-1:OW]});
        chk("R4 sample3 Q", {{(OW-15){1'b0}}, out_data[63:48]}, {{(OW-15){1'b0}}, w[127:112]});
        @(negedge clk_fast);
        chk("R7 zero after word", {out_valid, out_data}, '0);

        // Continuous burst (R6).
        for (int i = 0; i < 4; i++) send(1'b0, i);
        beats = 0; bubbles = 0; low_run = 0; started = 1'b0;
        mon_on = 1'b1;
        for (int i = 0; i < 40; i++) send(1'b1, 200 + i);
        for (int i = 0; i < 5; i++) send(1'b0, i);
        mon_on = 1'b0;
        chk("R6 bubble count", {{OW{1'b0}}, 1'(bubbles != 0)}, '0);
        chk("R6 beat count", {{(OW-31){1'b0}}, 32'(beats)}, {{(OW-31){1'b0}}, 32'd80});

        // Sparse patterns for phase alignment (R8).
        for (int i = 0; i < 30; i++) send(i % 2 == 0, 400 + i);
        for (int i = 0; i < 30; i++) send(i % 3 == 1, 500 + i);
        for (int i = 0; i < 20; i++) send((i % 5 == 0) || (i % 7 == 3), 600 + i);
        for (int i = 0; i < 4; i++) send(1'b0, i);

        // Reset in the middle of a stream (R9, R1).
        for (int i = 0; i < 6; i++) send(1'b1, 700 + i);
        ready_mon = 1'b0;
        @(posedge clk_slow);
        #2;
        rst_slow_n = 1'b0;
        in_valid   = 1'b0;
        repeat (3) @(posedge clk_slow);
        @(negedge clk_fast);
        chk("R9 cleared by reset", {out_valid, out_data}, '0);
        chk("R1 ready dropped", {{OW{1'b0}}, in_ready}, '0);
        @(posedge clk_slow);
        #2 rst_slow_n = 1'b1;
        @(posedge clk_slow);
        #2 ready_mon = 1'b1;
        for (int i = 0; i < 6; i++) send(1'b0, i);
        @(negedge clk_fast);
        chk("R9 zero after reset", {out_valid, out_data}, '0);
        for (int i = 0; i < 12; i++) send(1'b1, 800 + i);
        for (int i = 0; i < 6; i++) send(1'b0, i);

        finish_up();
    end

endmodule